// File: doc/BRIEF.md
# Key-Protected Always-On Watchdog Timer

This block is a watchdog that runs from a slow, always-powered clock of nominally 32768 Hz. Software reaches it over a simple 32-bit register bus with a write strobe, an address and write data, and a read data path that is combinational from the addressed register. A 31-bit counter advances once per clock while counting is enabled. A right-shifted 16-bit window of that counter, selected by a 4-bit scale field, is compared with a 16-bit threshold. When the window reaches the threshold, a sticky interrupt flag is raised. The block can also return the counter to zero on that match, which gives a periodic tick, and it can emit a one-clock reset request.

Every write to a protected register must directly follow a write of a fixed unlock word to the key register. The unlock is spent by the very next register write of any kind. Restarting the count needs a fixed magic word written to the feed register. Bus accesses are synchronous to the slow clock.

Top module: `wdog_aon`

## Requirements
- R1: After reset every register reads 0. The configuration sits at offset 0x00, the counter at 0x08, the scaled view at 0x10, feed at 0x18, key at 0x1C and threshold at 0x20. Feed always reads 0, and an unmapped offset reads 0.
- R2: The configuration word holds the scale in bits [3:0], the reset enable in bit 8, clear-on-match in bit 9, the always-count enable in bit 12, the count-while-awake enable in bit 13 and the interrupt flag in bit 28. An unlocked write of 0xFFFFFFFF reads back 0x1000330F, and an unlocked write of 0 reads back 0.
- R3: Writing 0x0051F15E to the key register unlocks the block. The key register reads 1 while unlocked and 0 otherwise.
- R4: A write to the configuration, counter or threshold register while locked leaves that register unchanged.
- R5: Any register write made while unlocked spends the unlock, including a feed write with a wrong value, so the key register then reads 0.
- R6: An unlocked feed write of 0x0D09F00D sets the counter to 0. An unlocked feed write of any other value leaves the counter unchanged.
- R7: The counter is 31 bits wide: an unlocked write of 0xAAAAAAAA reads back as 0x2AAAAAAA.
- R8: The scaled register reads bits [scale+15:scale] of the counter, zero-extended, for each scale from 0 to 15.
- R9: The counter increments by one per clock when bit 12 is set, or when bit 13 is set and the core-awake input is high. Otherwise it holds its value, and it resumes from the held value when enabled again.
- R10: While counting is enabled, the interrupt flag (bit 28, also driven on the interrupt output) sets in the cycle after the scaled view is greater than or equal to the threshold. It stays set until an unlocked configuration write clears it.
- R11: With bit 9 set, a match cycle returns the counter to 0 and the flag still sets. A threshold of T therefore gives a count that cycles through 0..T.
- R12: With bit 8 set, the reset-request output is high for exactly one clock in the cycle after the match condition first becomes true. With bit 8 clear, it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on low-frequency clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 6 | Byte offset of the register accessed |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the register at addr (combinational) |
| coreAwake | input | 1 | High while the core is awake; gates counting when bit 13 is set |
| irqPending | output | 1 | Sticky interrupt flag |
| resetReq | output | 1 | One-clock reset request |

## Verification
All register state changes at the clock edge that captures a write. Because read data is combinational from the addressed register, a write's effect can be read in the same clock period that follows that edge. The counter steps on each edge after the edge that stored the enable. The interrupt flag and the reset request are registered, so each appears one edge after the cycle in which the scaled view first met the threshold. The bench model updates at each rising edge from the inputs that were present during the cycle before it. At every falling edge it compares the read data for the current address, the flag and the reset request, so every result is checked exactly in the cycle it is due.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  // register offsets decoded by software
  localparam int OFF_CFG    = 'h00;
  localparam int OFF_COUNT  = 'h08;
  localparam int OFF_SCALED = 'h10;
  localparam int OFF_FEED   = 'h18;
  localparam int OFF_KEY    = 'h1C;
  localparam int OFF_CMP    = 'h20;

  // configuration word bit positions
  localparam int CFG_RSTEN  = 8;
  localparam int CFG_ZERO   = 9;
  localparam int CFG_ALWAYS = 12;
  localparam int CFG_AWAKE  = 13;
  localparam int CFG_PEND   = 28;

  localparam logic [31:0] UNLOCK_WORD = 32'h0051_F15E;
  localparam logic [31:0] FEED_WORD   = 32'h0D09_F00D;

  // control -> datapath strobes
  typedef struct packed {
    logic cntLoad;
    logic feedClear;
    logic cmpLoad;
    logic countEn;
    logic zeroOnMatch;
  } wdogStrobe_t;
endpackage

// File: rtl/wdog_datapath.sv
`timescale 1ns/1ps
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CNT_W   = 31,
  parameter int CMP_W   = 16,
  parameter int SCALE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  wdogStrobe_t        strobe,
  input  logic [SCALE_W-1:0] scale,
  input  logic [CNT_W-1:0]   loadCount,
  input  logic [CMP_W-1:0]   loadCmp,
  output logic [CNT_W-1:0]   count,
  output logic [CMP_W-1:0]   scaled,
  output logic [CMP_W-1:0]   cmpValue,
  output logic               matchHit,
  output logic               matchRise
);
  logic [CNT_W-1:0] countQ;
  logic [CMP_W-1:0] cmpQ;
  logic             matchPrevQ;

  always_comb begin
    scaled    = CMP_W'(countQ >> scale);
    matchHit  = strobe.countEn && (scaled >= cmpQ);
    matchRise = matchHit && !matchPrevQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ     <= '0;
      cmpQ       <= '0;
      matchPrevQ <= 1'b0;
    end else begin
      if (strobe.cntLoad)                        countQ <= loadCount;
      else if (strobe.feedClear)                 countQ <= '0;
      else if (matchHit && strobe.zeroOnMatch)   countQ <= '0;
      else if (strobe.countEn)                   countQ <= countQ + 1'b1;
      if (strobe.cmpLoad) cmpQ <= loadCmp;
      matchPrevQ <= matchHit;
    end
  end

  assign count    = countQ;
  assign cmpValue = cmpQ;

  // R9: with counting off and no load, the counter holds
  p_freeze_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.countEn && !strobe.cntLoad && !strobe.feedClear) |=> $stable(countQ));

  // R11: a match in clear-on-match mode returns the count to zero
  p_zero_on_match_r11: assert property (@(posedge clk) disable iff (!rstN)
    (matchHit && strobe.zeroOnMatch && !strobe.cntLoad) |=> (countQ == '0));

  // R6: a valid feed clears the counter
  p_feed_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.feedClear && !strobe.cntLoad) |=> (countQ == '0));
endmodule

// File: rtl/wdog_ctrl.sv
`timescale 1ns/1ps
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 31,
  parameter int CMP_W   = 16,
  parameter int SCALE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               coreAwake,
  input  logic               matchHit,
  input  logic               matchRise,
  input  logic [CNT_W-1:0]   dpCount,
  input  logic [CMP_W-1:0]   dpScaled,
  input  logic [CMP_W-1:0]   dpCmp,
  output wdogStrobe_t        strobe,
  output logic [SCALE_W-1:0] scale,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqPending,
  output logic               resetReq
);
  logic               unlockQ;
  logic [SCALE_W-1:0] scaleQ;
  logic               rstEnQ, zeroQ, alwaysQ, awakeQ, pendQ, resetReqQ;
  logic               selCfg, selCount, selScaled, selFeed, selKey, selCmp;
  logic               wrOk, cfgWrite;
  logic [DATA_W-1:0]  cfgWord;

  always_comb begin
    selCfg    = (addr == ADDR_W'(OFF_CFG));
    selCount  = (addr == ADDR_W'(OFF_COUNT));
    selScaled = (addr == ADDR_W'(OFF_SCALED));
    selFeed   = (addr == ADDR_W'(OFF_FEED));
    selKey    = (addr == ADDR_W'(OFF_KEY));
    selCmp    = (addr == ADDR_W'(OFF_CMP));
    wrOk      = wrEn && unlockQ;
    cfgWrite  = wrOk && selCfg;

    strobe.cntLoad     = wrOk && selCount;
    strobe.feedClear   = wrOk && selFeed && (wrData == DATA_W'(FEED_WORD));
    strobe.cmpLoad     = wrOk && selCmp;
    strobe.countEn     = alwaysQ || (awakeQ && coreAwake);
    strobe.zeroOnMatch = zeroQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlockQ   <= 1'b0;
      scaleQ    <= '0;
      rstEnQ    <= 1'b0;
      zeroQ     <= 1'b0;
      alwaysQ   <= 1'b0;
      awakeQ    <= 1'b0;
      pendQ     <= 1'b0;
      resetReqQ <= 1'b0;
    end else begin
      if (wrEn) unlockQ <= selKey && (wrData == DATA_W'(UNLOCK_WORD));
      if (cfgWrite) begin
        scaleQ  <= wrData[SCALE_W-1:0];
        rstEnQ  <= wrData[CFG_RSTEN];
        zeroQ   <= wrData[CFG_ZERO];
        alwaysQ <= wrData[CFG_ALWAYS];
        awakeQ  <= wrData[CFG_AWAKE];
      end
      pendQ     <= (cfgWrite ? wrData[CFG_PEND] : pendQ) | matchHit;
      resetReqQ <= rstEnQ && matchRise;
    end
  end

  always_comb begin
    cfgWord                = '0;
    cfgWord[SCALE_W-1:0]   = scaleQ;
    cfgWord[CFG_RSTEN]     = rstEnQ;
    cfgWord[CFG_ZERO]      = zeroQ;
    cfgWord[CFG_ALWAYS]    = alwaysQ;
    cfgWord[CFG_AWAKE]     = awakeQ;
    cfgWord[CFG_PEND]      = pendQ;
    rdData = '0;
    if (selCfg)    rdData = cfgWord;
    if (selCount)  rdData = DATA_W'(dpCount);
    if (selScaled) rdData = DATA_W'(dpScaled);
    if (selKey)    rdData = DATA_W'(unlockQ);
    if (selCmp)    rdData = DATA_W'(dpCmp);
  end

  assign scale      = scaleQ;
  assign irqPending = pendQ;
  assign resetReq   = resetReqQ;

  // R5: a non-key write spends the unlock
  p_single_use_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !selKey) |=> !unlockQ);

  // R4: locked configuration writes change no field (flag may still set by a match)
  p_locked_cfg_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !unlockQ && selCfg && !matchHit) |=> $stable(cfgWord));

  // R10: flag is sticky without a clearing write
  p_pending_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ && !cfgWrite) |=> pendQ);

  // R12: reset request never lasts two clocks
  p_reset_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    resetReqQ |=> !resetReqQ);
endmodule

// File: rtl/wdog_aon.sv
`timescale 1ns/1ps
module wdog_aon
  import wdog_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 31,
  parameter int CMP_W   = 16,
  parameter int SCALE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              coreAwake,
  output logic              irqPending,
  output logic              resetReq
);
  wdogStrobe_t        strobe;
  logic [SCALE_W-1:0] scale;
  logic [CNT_W-1:0]   count;
  logic [CMP_W-1:0]   scaled, cmpValue;
  logic               matchHit, matchRise;

  wdog_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
              .CMP_W(CMP_W), .SCALE_W(SCALE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .coreAwake(coreAwake), .matchHit(matchHit), .matchRise(matchRise),
    .dpCount(count), .dpScaled(scaled), .dpCmp(cmpValue),
    .strobe(strobe), .scale(scale), .rdData(rdData),
    .irqPending(irqPending), .resetReq(resetReq)
  );

  wdog_datapath #(.CNT_W(CNT_W), .CMP_W(CMP_W), .SCALE_W(SCALE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .scale(scale),
    .loadCount(wrData[CNT_W-1:0]), .loadCmp(wrData[CMP_W-1:0]),
    .count(count), .scaled(scaled), .cmpValue(cmpValue),
    .matchHit(matchHit), .matchRise(matchRise)
  );
endmodule

// File: tb/wdog_aon_tb.sv
`timescale 1ns/1ps
module wdog_aon_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_CFG = 6'h00, A_CNT = 6'h08, A_SCL = 6'h10,
                         A_FEED = 6'h18, A_KEY = 6'h1C, A_CMP = 6'h20;
  localparam logic [31:0] KEY = 32'h0051F15E, FEED = 32'h0D09F00D;
  localparam logic [31:0] B_RST = 32'h100, B_ZERO = 32'h200,
                          B_ALW = 32'h1000, B_AWK = 32'h2000;

  logic clk = 0, rstN = 0, wrEn = 0, coreAwake = 0;
  logic [5:0] addr = 0;
  logic [31:0] wrData = 0;
  logic [31:0] rdData;
  logic irqPending, resetReq;
  int checks = 0, fails = 0;
  bit done = 0;

  wdog_aon u_dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .coreAwake(coreAwake), .irqPending(irqPending), .resetReq(resetReq));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [30:0] mCnt; logic [15:0] mCmp; logic [3:0] mScale;
  logic mRstEn, mZero, mAlw, mAwk, mPend, mUnl, mRst, mPrevHit;

  function automatic logic [15:0] mScaled();
    logic [30:0] s; s = mCnt >> mScale; return s[15:0];
  endfunction

  function automatic logic [31:0] mRead(input logic [5:0] a);
    case (a)
      A_CFG: return {3'b0, mPend, 14'b0, mAwk, mAlw, 2'b0, mZero, mRstEn, 4'b0, mScale};
      A_CNT: return {1'b0, mCnt};
      A_SCL: return {16'b0, mScaled()};
      A_KEY: return {31'b0, mUnl};
      A_CMP: return {16'b0, mCmp};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mCmp = 0; mScale = 0; mRstEn = 0; mZero = 0; mAlw = 0; mAwk = 0;
      mPend = 0; mUnl = 0; mRst = 0; mPrevHit = 0;
    end else begin
      bit en, hit, ok;
      en  = mAlw || (mAwk && coreAwake);
      hit = en && (mScaled() >= mCmp);
      ok  = wrEn && mUnl;
      mRst = mRstEn && hit && !mPrevHit;
      mPrevHit = hit;
      if (ok && addr == A_CNT) mCnt = wrData[30:0];
      else if (ok && addr == A_FEED && wrData == FEED) mCnt = 0;
      else if (hit && mZero) mCnt = 0;
      else if (en) mCnt = mCnt + 1;
      if (ok && addr == A_CMP) mCmp = wrData[15:0];
      mPend = ((ok && addr == A_CFG) ? wrData[28] : mPend) | hit;
      if (ok && addr == A_CFG) begin
        mScale = wrData[3:0]; mRstEn = wrData[8]; mZero = wrData[9];
        mAlw = wrData[12]; mAwk = wrData[13];
      end
      if (wrEn) mUnl = (addr == A_KEY) && (wrData == KEY);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (rstN && !done) begin
    chk("R1/R8 model read", rdData, mRead(addr));
    chk("R10 model flag", {31'b0, irqPending}, {31'b0, mPend});
    chk("R12 model reset request", {31'b0, resetReq}, {31'b0, mRst});
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wrEn = 1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 0;
  endtask
  task automatic kwr(input logic [5:0] a, input logic [31:0] d);
    wr(A_KEY, KEY); wr(a, d);
  endtask
  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    addr = a; @(negedge clk); v = rdData; @(posedge clk); #1;
  endtask
  task automatic idle(input int n);
    repeat (n) @(posedge clk); #1;
  endtask

  task automatic finishRun();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [31:0] v, v1, v2;
    int maxv, pulses; bit prevP;
    repeat (3) @(posedge clk); #1; rstN = 1; idle(1);

    // R1: reset values
    rd(A_CFG, v); chk("R1 cfg reset", v, 0);
    rd(A_CNT, v); chk("R1 count reset", v, 0);
    rd(A_KEY, v); chk("R1 key reset", v, 0);
    rd(A_FEED, v); chk("R1 feed reads 0", v, 0);

    // R4: locked writes ignored
    wr(A_CNT, 32'hBEEF); rd(A_CNT, v); chk("R4 locked count write", v, 0);
    wr(A_CMP, 32'hBEEF); rd(A_CMP, v); chk("R4 locked cmp write", v, 0);
    wr(A_CFG, 32'hFFFFFFFF); rd(A_CFG, v); chk("R4 locked cfg write", v, 0);

    // R7 and R5
    kwr(A_CNT, 32'hAAAAAAAA); rd(A_CNT, v); chk("R7 31-bit counter", v, 32'h2AAAAAAA);
    rd(A_KEY, v); chk("R5 unlock spent", v, 0);

    // R3, R5, R6
    wr(A_KEY, KEY); rd(A_KEY, v); chk("R3 key reads 1", v, 1);
    wr(A_FEED, 32'hAAAAAAAA); rd(A_CNT, v); chk("R6 wrong feed no effect", v, 32'h2AAAAAAA);
    rd(A_KEY, v); chk("R5 wrong feed spends unlock", v, 0);
    wr(A_KEY, 32'hFFFF); rd(A_KEY, v); chk("R3 wrong key stays locked", v, 0);
    kwr(A_FEED, FEED); rd(A_CNT, v); chk("R6 magic feed clears", v, 0);

    // R2: configuration layout
    kwr(A_CMP, 32'hFFFF); rd(A_CMP, v); chk("R4 unlocked cmp write", v, 32'hFFFF);
    kwr(A_CFG, 32'hFFFFFFFF); rd(A_CFG, v); chk("R2 cfg all ones", v, 32'h1000330F);
    kwr(A_CFG, 32'h0); rd(A_CFG, v); chk("R2 cfg zero", v, 0);

    // R8: scaled view
    kwr(A_CNT, 32'h12345678);
    for (int s = 0; s < 16; s++) begin
      kwr(A_CFG, s);
      rd(A_SCL, v); chk($sformatf("R8 scale %0d", s), v, (32'h12345678 >> s) & 32'hFFFF);
    end

    // R9: count, freeze, resume
    kwr(A_CFG, 0); kwr(A_CNT, 0); kwr(A_CMP, 20);
    kwr(A_CFG, B_ALW); idle(5);
    kwr(A_CFG, 0);
    rd(A_CNT, v1); idle(5); rd(A_CNT, v2); chk("R9 frozen count holds", v2, v1);
    kwr(A_CFG, B_ALW); idle(40); rd(A_CNT, v);
    chk("R9 resumed count advanced", {31'b0, v > v1}, 1);
    chk("R10 flag set on match", {31'b0, irqPending}, 1);

    // R10: sticky, then cleared
    kwr(A_CNT, 0); idle(3); chk("R10 flag sticky", {31'b0, irqPending}, 1);
    kwr(A_CFG, B_ALW); rd(A_CFG, v); chk("R10 flag cleared", v & 32'h10000000, 0);

    // R9: count-while-awake
    kwr(A_CFG, B_AWK); kwr(A_CNT, 0); idle(5);
    rd(A_CNT, v); chk("R9 asleep no count", v, 0);
    coreAwake = 1; idle(5); rd(A_CNT, v); chk("R9 awake counts", v, 5);
    coreAwake = 0;

    // R11: periodic clear-on-match, reset disabled
    kwr(A_CMP, 5); kwr(A_CNT, 0); kwr(A_CFG, B_ALW | B_ZERO);
    maxv = 0; pulses = 0; addr = A_CNT;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (int'(rdData) > maxv) maxv = int'(rdData);
      if (resetReq) pulses++;
    end
    @(posedge clk); #1;
    chk("R11 periodic count peak", maxv, 5);
    chk("R11 flag set in periodic mode", {31'b0, irqPending}, 1);
    chk("R12 no request when disabled", pulses, 0);

    // R12: reset request pulses
    kwr(A_CFG, B_ALW | B_ZERO | B_RST);
    pulses = 0; prevP = 0; maxv = 0;
    for (int i = 0; i < 36; i++) begin
      @(negedge clk);
      if (resetReq) pulses++;
      if (resetReq && prevP) maxv++;
      prevP = resetReq;
    end
    @(posedge clk); #1;
    chk("R12 request pulses seen", {31'b0, pulses >= 5}, 1);
    chk("R12 request one clock wide", maxv, 0);

    finishRun();
  end
endmodule